// File: doc/BRIEF.md
# Supervisor User-Page Access Checker

This block decides whether a memory access may touch a page, given the user-accessible flag in that page's translation entry. It takes the hart's current privilege, the modify-privilege controls (an enable and a saved previous mode), the access kind and a paging-active flag. It works out the effective privilege of the access and raises a page-fault flag when the user-page rule forbids the access. The decision is purely combinational. The only state is the supervisor-may-touch-user-pages control bit, which software writes through a write-enable port.

The translation logic sits beside the block. Each cycle it presents one access with a valid strobe, together with the U flag of the page it resolved. The fault output and its kind code go straight to trap logic. Read, write and execute permission bits, the table walk and the TLB live elsewhere.

A parameter selects whether supervisor mode exists. When it is absent, the control bit reads as zero and ignores writes.

Top module: `upage_guard`

## Requirements
- R1: Privilege codes are 2'b00 user, 2'b01 supervisor, 2'b10 reserved and 2'b11 machine. Access kind codes are 2'b00 load, 2'b01 store, 2'b10 fetch and 2'b11 handled as a load. `eff_priv_o` equals `mpp_i` when `mprv_i` is 1 and the kind is not fetch; otherwise it equals `priv_i`.
- R2: With paging on and effective privilege supervisor, a load or store to a page with U=1 faults while the stored control bit is 0.
- R3: With paging on and effective privilege supervisor, a load or store to a U=1 page does not fault while the control bit is 1.
- R4: With paging on and effective privilege supervisor, an access of any kind to a U=0 page never faults, whatever the control bit holds.
- R5: With paging on and effective privilege user, an access to a U=0 page faults and an access to a U=1 page does not, whatever the control bit holds.
- R6: An access whose effective privilege is machine never faults.
- R7: With `paging_i` at 0, no access faults, whatever the U flag and the control bit hold.
- R8: An access from machine mode with `mprv_i`=1 and `mpp_i` = supervisor is judged as a supervisor access, so the control bit decides whether it may reach a U=1 page.
- R9: A fetch ignores `mprv_i`. A supervisor fetch from a U=1 page faults even when the control bit is 1.
- R10: `fault_o` is 1 only while `valid_i` is 1. `fault_kind_o` repeats `acc_kind_i` while `fault_o` is 1 and is 2'b00 otherwise.
- R11: The control bit resets to 0 under `rst_ni`. When `sum_we_i` is 1 at a rising edge, `sum_wdata_i` is stored. The new value is seen on `sum_o`, and used for accesses, from the next cycle on. An access in the write cycle still sees the old value.
- R12: With `HAS_SMODE`=0, `sum_o` is always 0, writes are ignored, and a supervisor load to a U=1 page faults.
- R13: With paging on, an access whose effective privilege is the reserved code 2'b10 faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sum_we_i | input | 1 | Write enable for the control bit |
| sum_wdata_i | input | 1 | Value to write into the control bit |
| sum_o | output | 1 | Current control bit |
| valid_i | input | 1 | Access present this cycle |
| priv_i | input | 2 | Current privilege mode |
| mprv_i | input | 1 | Modify-privilege enable for data accesses |
| mpp_i | input | 2 | Privilege used for data accesses while `mprv_i` is 1 |
| paging_i | input | 1 | Page-based translation active |
| pte_u_i | input | 1 | Page is user-accessible |
| acc_kind_i | input | 2 | Access kind |
| eff_priv_o | output | 2 | Effective privilege of the access |
| fault_o | output | 1 | Page fault from the user-page rule |
| fault_kind_o | output | 2 | Kind of the faulting access, 0 when there is no fault |

## Verification
A write of the control bit and an access that depends on it can fall in the same cycle. The bench provokes this by raising `sum_we_i` in the same cycle as a supervisor load to a U=1 page. It expects the access to be judged with the old value, so a fault is expected, and it expects the identical access one cycle later to pass. The scoreboard records the expected control value before each write, so the comparison of `sum_o` and `fault_o` shows whether the update landed exactly one edge later.

// File: rtl/upage_pkg.sv
`timescale 1ns/1ps
package upage_pkg;
  localparam int PRIV_W = 2;
  localparam int KIND_W = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef enum logic [KIND_W-1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;
endpackage

// File: rtl/upage_sum_reg.sv
`timescale 1ns/1ps
module upage_sum_reg #(
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wdata_i,
  output logic sum_o
);
  generate
    if (HAS_SMODE) begin : g_reg
      logic sum_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   sum_q <= 1'b0;
        else if (we_i) sum_q <= wdata_i;
      end
      assign sum_o = sum_q;
    end else begin : g_tied
      assign sum_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/upage_eff_priv.sv
`timescale 1ns/1ps
module upage_eff_priv
  import upage_pkg::*;
(
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              mprv_i,
  input  logic [PRIV_W-1:0] mpp_i,
  input  logic [KIND_W-1:0] kind_i,
  output logic [PRIV_W-1:0] eff_o
);
  logic data_acc;
  assign data_acc = (kind_i != ACC_FETCH);

  always_comb begin
    eff_o = priv_i;
    if (mprv_i && data_acc) eff_o = mpp_i;
  end
endmodule

// File: rtl/upage_perm.sv
`timescale 1ns/1ps
module upage_perm
  import upage_pkg::*;
(
  input  logic [PRIV_W-1:0] eff_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              sum_i,
  input  logic              paging_i,
  input  logic              pte_u_i,
  input  logic              valid_i,
  output logic              fault_o,
  output logic [KIND_W-1:0] fault_kind_o
);
  logic is_fetch;
  logic deny;

  assign is_fetch = (kind_i == ACC_FETCH);

  always_comb begin
    deny = 1'b0;
    case (eff_i)
      PRIV_U:   deny = !pte_u_i;
      // the control bit widens data reach only; it never lowers privilege
      PRIV_S:   deny = pte_u_i && (is_fetch || !sum_i);
      PRIV_RSV: deny = 1'b1;
      default:  deny = 1'b0;
    endcase
  end

  assign fault_o      = valid_i && paging_i && deny;
  assign fault_kind_o = fault_o ? kind_i : '0;
endmodule

// File: rtl/upage_guard.sv
`timescale 1ns/1ps
module upage_guard
  import upage_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sum_we_i,
  input  logic              sum_wdata_i,
  output logic              sum_o,
  input  logic              valid_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              mprv_i,
  input  logic [PRIV_W-1:0] mpp_i,
  input  logic              paging_i,
  input  logic              pte_u_i,
  input  logic [KIND_W-1:0] acc_kind_i,
  output logic [PRIV_W-1:0] eff_priv_o,
  output logic              fault_o,
  output logic [KIND_W-1:0] fault_kind_o
);
  logic              sum_q;
  logic [PRIV_W-1:0] eff;

  upage_sum_reg #(.HAS_SMODE(HAS_SMODE)) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sum_we_i),
    .wdata_i (sum_wdata_i),
    .sum_o   (sum_q)
  );

  upage_eff_priv u_eff (
    .priv_i (priv_i),
    .mprv_i (mprv_i),
    .mpp_i  (mpp_i),
    .kind_i (acc_kind_i),
    .eff_o  (eff)
  );

  upage_perm u_perm (
    .eff_i        (eff),
    .kind_i       (acc_kind_i),
    .sum_i        (sum_q),
    .paging_i     (paging_i),
    .pte_u_i      (pte_u_i),
    .valid_i      (valid_i),
    .fault_o      (fault_o),
    .fault_kind_o (fault_kind_o)
  );

  assign sum_o      = sum_q;
  assign eff_priv_o = eff;
endmodule

// File: rtl/upage_guard_chk.sv
`timescale 1ns/1ps
module upage_guard_chk
  import upage_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sum_we_i,
  input logic              sum_wdata_i,
  input logic              sum_o,
  input logic              valid_i,
  input logic [PRIV_W-1:0] priv_i,
  input logic              paging_i,
  input logic              pte_u_i,
  input logic [KIND_W-1:0] acc_kind_i,
  input logic [PRIV_W-1:0] eff_priv_o,
  input logic              fault_o,
  input logic [KIND_W-1:0] fault_kind_o
);
  a_r10_idle_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !fault_o);

  a_r10_kind_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fault_kind_o == acc_kind_i);

  a_r10_kind_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> fault_kind_o == '0);

  a_r7_paging_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !paging_i |-> !fault_o);

  a_r6_machine_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_priv_o == PRIV_M |-> !fault_o);

  a_r9_fetch_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_kind_i == ACC_FETCH |-> eff_priv_o == priv_i);

  a_r4_super_own_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_priv_o == PRIV_S && !pte_u_i) |-> !fault_o);

  a_r11_sum_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_we_i |=> sum_o == (HAS_SMODE ? $past(sum_wdata_i) : 1'b0));

  a_r11_sum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sum_we_i |=> $stable(sum_o));

  a_r12_tied_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_SMODE |-> !sum_o);
endmodule

bind upage_guard upage_guard_chk #(.HAS_SMODE(HAS_SMODE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sum_we_i     (sum_we_i),
  .sum_wdata_i  (sum_wdata_i),
  .sum_o        (sum_o),
  .valid_i      (valid_i),
  .priv_i       (priv_i),
  .paging_i     (paging_i),
  .pte_u_i      (pte_u_i),
  .acc_kind_i   (acc_kind_i),
  .eff_priv_o   (eff_priv_o),
  .fault_o      (fault_o),
  .fault_kind_o (fault_kind_o)
);

// File: tb/upage_guard_bench.sv
`timescale 1ns/1ps
module upage_guard_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sum_we_i = 1'b0;
  logic       sum_wdata_i = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] priv_i = 2'b00;
  logic       mprv_i = 1'b0;
  logic [1:0] mpp_i = 2'b00;
  logic       paging_i = 1'b0;
  logic       pte_u_i = 1'b0;
  logic [1:0] acc_kind_i = 2'b00;

  logic       sum_o, fault_o, ns_sum, ns_fault;
  logic [1:0] eff_priv_o, fault_kind_o, ns_eff, ns_kind;

  always #2.5 clk_i = ~clk_i;

  upage_guard #(.HAS_SMODE(1'b1)) u_upage_guard (
    .clk_i, .rst_ni, .sum_we_i, .sum_wdata_i, .sum_o,
    .valid_i, .priv_i, .mprv_i, .mpp_i, .paging_i, .pte_u_i, .acc_kind_i,
    .eff_priv_o, .fault_o, .fault_kind_o
  );

  upage_guard #(.HAS_SMODE(1'b0)) u_upage_guard_ns (
    .clk_i, .rst_ni, .sum_we_i, .sum_wdata_i, .sum_o(ns_sum),
    .valid_i, .priv_i, .mprv_i, .mpp_i, .paging_i, .pte_u_i, .acc_kind_i,
    .eff_priv_o(ns_eff), .fault_o(ns_fault), .fault_kind_o(ns_kind)
  );

  typedef struct {
    logic [1:0] eff;
    logic       fault;
    logic [1:0] kind;
    logic       sum;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  logic model_sum = 1'b0;

  function automatic logic ref_fault(logic [1:0] e, logic [1:0] k, logic s,
                                     logic pg, logic u, logic v);
    if (!v || !pg)       return 1'b0;
    if (e == 2'b11)      return 1'b0;
    if (e == 2'b10)      return 1'b1;
    if (e == 2'b00)      return !u;
    if (!u)              return 1'b0;
    if (k == 2'b10)      return 1'b1;
    return !s;
  endfunction

  task automatic drive(input logic [1:0] p, input logic mp, input logic [1:0] pp,
                       input logic [1:0] k, input logic pg, input logic u,
                       input logic v, input logic we, input logic wd,
                       input string tag);
    exp_t it;
    @(negedge clk_i);
    priv_i = p; mprv_i = mp; mpp_i = pp; acc_kind_i = k;
    paging_i = pg; pte_u_i = u; valid_i = v; sum_we_i = we; sum_wdata_i = wd;
    it.eff   = (mp && k != 2'b10) ? pp : p;
    it.fault = ref_fault(it.eff, k, model_sum, pg, u, v);
    it.kind  = it.fault ? k : 2'b00;
    it.sum   = model_sum;
    it.tag   = tag;
    exp_q.push_back(it);
    if (we) model_sum = wd;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops one expectation per cycle, sampled 1 ns after the driving edge
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (eff_priv_o !== it.eff || fault_o !== it.fault ||
            fault_kind_o !== it.kind || sum_o !== it.sum) begin
          failures++;
          $display("FAIL %s actual eff=%0d fault=%0d kind=%0d sum=%0d expected eff=%0d fault=%0d kind=%0d sum=%0d",
                   it.tag, eff_priv_o, fault_o, fault_kind_o, sum_o,
                   it.eff, it.fault, it.kind, it.sum);
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check(sum_o === 1'b0, "R11 reset value", sum_o, 0);
    rst_ni = 1'b1;

    // R1 effective privilege selection
    drive(2'b00, 1, 2'b11, 2'b00, 1, 0, 1, 0, 0, "R1 mprv load takes mpp");
    drive(2'b11, 1, 2'b00, 2'b10, 1, 1, 1, 0, 0, "R1 fetch keeps priv");
    drive(2'b01, 0, 2'b11, 2'b01, 1, 1, 1, 0, 0, "R1 mprv off keeps priv");
    // control bit at 0
    drive(2'b01, 0, 2'b00, 2'b00, 1, 1, 1, 0, 0, "R2 super load user page");
    drive(2'b01, 0, 2'b00, 2'b01, 1, 1, 1, 0, 0, "R2 super store user page");
    drive(2'b01, 0, 2'b00, 2'b11, 1, 1, 1, 0, 0, "R10 kind 3 echoed");
    drive(2'b01, 0, 2'b00, 2'b00, 1, 0, 1, 0, 0, "R4 super own page sum0");
    drive(2'b00, 0, 2'b00, 2'b00, 1, 0, 1, 0, 0, "R5 user own-less page");
    drive(2'b00, 0, 2'b00, 2'b01, 1, 1, 1, 0, 0, "R5 user page ok");
    drive(2'b11, 0, 2'b00, 2'b00, 1, 0, 1, 0, 0, "R6 machine free");
    drive(2'b01, 0, 2'b00, 2'b00, 0, 1, 1, 0, 0, "R7 paging off super");
    drive(2'b00, 0, 2'b00, 2'b01, 0, 0, 1, 0, 0, "R7 paging off user");
    drive(2'b01, 0, 2'b00, 2'b00, 1, 1, 0, 0, 0, "R10 no strobe");
    drive(2'b10, 0, 2'b00, 2'b00, 1, 1, 1, 0, 0, "R13 reserved priv");
    drive(2'b11, 1, 2'b01, 2'b00, 1, 1, 1, 0, 0, "R8 mprv super sum0 faults");
    // write in the same cycle as a dependent access: old value applies
    drive(2'b01, 0, 2'b00, 2'b00, 1, 1, 1, 1, 1, "R11 write cycle uses old");
    drive(2'b01, 0, 2'b00, 2'b00, 1, 1, 1, 0, 0, "R3 next cycle allowed");
    #1;
    check(ns_sum === 1'b0, "R12 tied sum", ns_sum, 0);
    check(ns_fault === 1'b1, "R12 super load faults", ns_fault, 1);
    drive(2'b01, 0, 2'b00, 2'b01, 1, 1, 1, 0, 0, "R3 super store user page");
    drive(2'b01, 0, 2'b00, 2'b01, 1, 0, 1, 0, 0, "R4 super own page sum1");
    drive(2'b01, 0, 2'b00, 2'b10, 1, 0, 1, 0, 0, "R4 super fetch own page");
    drive(2'b00, 0, 2'b00, 2'b00, 1, 0, 1, 0, 0, "R5 user faults sum1");
    drive(2'b01, 0, 2'b00, 2'b10, 1, 1, 1, 0, 0, "R9 super fetch user page");
    drive(2'b01, 1, 2'b11, 2'b10, 1, 1, 1, 0, 0, "R9 fetch ignores mprv");
    drive(2'b11, 1, 2'b01, 2'b00, 1, 1, 1, 0, 0, "R8 mprv super sum1 ok");
    drive(2'b11, 1, 2'b01, 2'b00, 0, 1, 0, 1, 0, "R11 clear bit");
    drive(2'b11, 1, 2'b01, 2'b01, 1, 1, 1, 0, 0, "R8 mprv super store sum0");
    drive(2'b11, 1, 2'b01, 2'b10, 1, 1, 1, 0, 0, "R9 mprv fetch stays machine");
    drive(2'b00, 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R11 holds");

    repeat (3) @(negedge clk_i);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule